// File: doc/BRIEF.md
# Adaptive Processing-Engine Gating Controller

This block decides how many packet-processing engines of a multi-engine network processor keep their clocks running. It watches two inputs: the number of threads waiting in the thread queue, and a flag raised when the internal packet buffer is full. From these it drives one registered clock-enable bit per engine. Engines are switched off or back on one at a time.

The block evaluates its inputs once every `PERIOD` clock cycles. At each evaluation a long thread queue counts as evidence that there are more engines than the traffic needs. This evidence builds up in a persistence counter. When the counter passes an adaptive threshold, the highest-numbered enabled engine is switched off. Each shutdown lowers the threshold, so the next shutdown comes sooner.

A full buffer is the opposite signal: the engines are not keeping up. A full buffer wakes the lowest-numbered disabled engine and raises the threshold, so that shutdowns become more reluctant. Real clock-gating cells, the engines and the buffers are outside this block. Its only outputs are the enables.

Top module: `pe_gate_ctrl`

## Requirements
- R1: During and after reset, with no evaluation yet performed, every bit of `pe_en` is 1, the threshold equals `THR_INIT` and the persistence counter is 0.
- R2: Evaluations happen on every `PERIOD`-th rising clock edge after reset is released. `pe_en` changes only on an evaluation edge.
- R3: At an evaluation without `buf_full`, a `queue_len` strictly greater than `Q_LIMIT` increments the persistence counter. A `queue_len` less than or equal to `Q_LIMIT` leaves the counter unchanged.
- R4: When the incremented counter is greater than the threshold, the highest-index set bit of `pe_en` is cleared. The threshold then drops by `STEP`, saturating at `THR_MIN`.
- R5: At an evaluation with `buf_full` = 1, the lowest-index clear bit of `pe_en` is set. The threshold then rises by `STEP`, saturating at `THR_MAX`.
- R6: The persistence counter returns to 0 whenever an engine is switched off or on.
- R7: `pe_en[0]` is never cleared. A shutdown request while only one engine is enabled is ignored. A wake-up request while all engines are enabled is ignored and leaves the threshold unchanged.
- R8: `pe_en` is always a contiguous run of ones starting at bit 0: engines 0..k-1 are enabled and the rest are disabled.
- R9: When `buf_full` is 1 at an evaluation, the wake-up takes priority: no engine is switched off and `queue_len` is not counted at that evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| queue_len | input | QW | Number of threads waiting for packets |
| buf_full | input | 1 | Internal packet buffer reports full |
| pe_en | output | NUM_PE | Registered per-engine clock enable, bit i for engine i |

## Verification
The threshold and the persistence counter never reach the ports directly. A wrong value in either shows up only as a shutdown that comes one or more evaluations too early or too late. The bench therefore checks `pe_en` after exact counts of evaluations, right around each expected shutdown. A threshold that fails to saturate is caught the same way: the first shutdown after a run of wake-ups arrives at the wrong evaluation. A counter that is not cleared on a wake-up is also caught this way: the shutdown fires only a few evaluations after that wake-up. A broken divider or mask update is visible at once, within one period, as an enable change at a non-evaluation edge or a non-contiguous mask.

// File: rtl/pe_gate_ctrl.sv
module pe_gate_ctrl #(
  parameter int NUM_PE   = 8,
  parameter int QW       = 6,
  parameter int Q_LIMIT  = 4,
  parameter int THR_INIT = 3,
  parameter int THR_MIN  = 1,
  parameter int THR_MAX  = 7,
  parameter int STEP     = 2,
  parameter int PERIOD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QW-1:0]     queue_len,
  input  logic              buf_full,
  output logic [NUM_PE-1:0] pe_en
);
  localparam int TW = $clog2(THR_MAX + STEP + 1);
  localparam int DW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] STEP_V = TW'(STEP);
  localparam logic [TW-1:0] MIN_V  = TW'(THR_MIN);
  localparam logic [TW-1:0] MAX_V  = TW'(THR_MAX);

  logic [DW-1:0] div;
  logic [TW-1:0] thr, cnt;
  logic [NUM_PE-1:0] en;

  wire tick   = (div == DW'(PERIOD - 1));
  wire busy   = (queue_len > QW'(Q_LIMIT));
  wire all_on = en[NUM_PE-1];
  wire one_on = (en[NUM_PE-1:1] == '0);

  wire [TW-1:0] cnt_inc = (&cnt) ? cnt : cnt + 1'b1;
  wire          over    = (cnt_inc > thr);
  wire [TW-1:0] thr_up  = (thr > MAX_V - STEP_V) ? MAX_V : thr + STEP_V;
  wire [TW-1:0] thr_dn  = (thr < MIN_V + STEP_V) ? MIN_V : thr - STEP_V;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
      en  <= '1;
      thr <= TW'(THR_INIT);
      cnt <= '0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (buf_full) begin
          if (!all_on) begin
            en  <= {en[NUM_PE-2:0], 1'b1};
            thr <= thr_up;
            cnt <= '0;
          end
        end else if (busy) begin
          if (over && !one_on) begin
            en  <= en >> 1;
            thr <= thr_dn;
            cnt <= '0;
          end else begin
            cnt <= cnt_inc;
          end
        end
      end
    end
  end

  assign pe_en = en;
endmodule

// File: rtl/pe_gate_chk.sv
module pe_gate_chk #(
  parameter int NUM_PE  = 8,
  parameter int TW      = 4,
  parameter int THR_MIN = 1,
  parameter int THR_MAX = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              buf_full,
  input logic [NUM_PE-1:0] pe_en,
  input logic [TW-1:0]     thr
);
  // R8
  contiguous_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_en[0] && ((pe_en & (pe_en + 1'b1)) == '0));

  // R2
  quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pe_en));

  // R5
  wake_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && buf_full && !pe_en[NUM_PE-1] |=> pe_en == {$past(pe_en[NUM_PE-2:0]), 1'b1});

  // R9
  no_shrink_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && buf_full |=> $countones(pe_en) >= $countones($past(pe_en)));

  // R4
  thr_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr >= TW'(THR_MIN) && thr <= TW'(THR_MAX));

  // R7
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pe_en == $past(pe_en)) || (pe_en == ($past(pe_en) >> 1))
             || (pe_en == {$past(pe_en[NUM_PE-2:0]), 1'b1}));
endmodule

bind pe_gate_ctrl pe_gate_chk #(
  .NUM_PE(NUM_PE), .TW(TW), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .buf_full(buf_full), .pe_en(pe_en), .thr(thr)
);

// File: tb/sim_pe_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pe_gate_ctrl;
  localparam int P = 4;
  logic clk = 0, rst_n = 0, buf_full = 0;
  logic [5:0] queue_len = 0;
  logic [7:0] pe_en;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pe_gate_ctrl u0 (.clk(clk), .rst_n(rst_n), .queue_len(queue_len),
                   .buf_full(buf_full), .pe_en(pe_en));

  task automatic check(input string tag, input logic [7:0] exp);
    total++;
    if (pe_en !== exp) begin
      bad++;
      $display("FAIL %s: pe_en=%h expected=%h", tag, pe_en, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n * P) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 8'hFF);
    rst_n = 1;
    check("R1 after release", 8'hFF);

    queue_len = 4; run(12); check("R3 length equal to limit not counted", 8'hFF);

    queue_len = 5;
    run(3); check("R3 counting below threshold", 8'hFF);
    run(1); check("R4 first shutdown", 8'h7F);
    run(1); check("R6 counter cleared", 8'h7F);
    run(1); check("R4 threshold at min", 8'h3F);
    run(2); check("R4 shutdown 3", 8'h1F);
    run(2); check("R4 shutdown 4", 8'h0F);
    run(2); check("R4 shutdown 5", 8'h07);
    run(2); check("R4 shutdown 6", 8'h03);
    run(2); check("R4 shutdown 7", 8'h01);
    run(6); check("R7 last engine kept", 8'h01);

    queue_len = 0; buf_full = 1;
    for (int k = 1; k < 8; k++) begin
      run(1); check("R5 wake-up step", 8'((16'd1 << (k + 1)) - 1));
    end
    run(3); check("R7 all on, wake ignored", 8'hFF);

    buf_full = 0; queue_len = 5;
    run(7); check("R5 threshold saturated at max", 8'hFF);
    run(1); check("R5 shutdown after max threshold", 8'h7F);

    run(5); check("R3 count below threshold", 8'h7F);
    buf_full = 1;
    run(1); check("R9 wake wins over shutdown", 8'hFF);
    buf_full = 0;
    run(7); check("R6 counter cleared by wake", 8'hFF);
    run(1); check("R6 shutdown after fresh count", 8'h7F);

    run(3); check("R3 partial count", 8'h7F);
    queue_len = 0;
    run(4); check("R3 idle queue holds", 8'h7F);
    queue_len = 5;
    run(2); check("R3 count kept across idle", 8'h7F);
    run(1); check("R3 shutdown after held count", 8'h3F);

    run(3); check("R2 before evaluation", 8'h3F);
    repeat (P - 1) @(posedge clk);
    @(negedge clk); check("R2 no change between evaluations", 8'h3F);
    @(posedge clk);
    @(negedge clk); check("R2 change on evaluation edge", 8'h1F);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule